// File: doc/BRIEF.md
# Key-Protected Power and Clock Control Unit

This unit sits on a simple register bus and holds two power control registers. The first sets the core clock divide code and the power-down flags for the crystal, the PLL, the peripheral domain and the core. The second turns the UART, PWM and SPI/I2C blocks on or off. Software cannot change either register with a single stray write. Each update has to be bracketed by key writes that sit next to it in the sequence of bus writes.

For the first register, one leading key is enough. For the second register, a leading key must come before the data write and a trailing key must follow it. The data write itself is only held as pending, and the register changes when the trailing key lands. Some power-down combinations in the first register are illegal, and the unit rejects them: the PLL and the peripheral domain cannot be switched off while a block that depends on them stays on. A wake-up input restores the core, peripheral and PLL flags.

The outputs are the clock divide select, one enable for each power domain and one enable for each peripheral. They come straight from the registers, so each one changes on the same clock edge that commits the write.

Top module: `pwr_ctl_keyed`

## Requirements
- R1: A write to the first power register (address 0x1) takes effect only if the write before it on the bus was 0x0001 to its key at address 0x0. Cycles without a write between the two do not count. Otherwise the write is ignored.
- R2: The second power register (address 0x3) changes only for the sequence: 0x0076 to address 0x2, then the data write, then 0x00B1 to address 0x4. The value commits when that trailing key is written. A wrong trailing key, or a data write with no leading key, leaves the register unchanged.
- R3: After reset the first power register reads 0x7B. Its bit 7 and its upper bits always read 0, even when written with 1.
- R4: Bits 2:0 of the first register drive clk_div_sel. The core rate is 10.24 MHz / 2^code. The reset code is 3.
- R5: Bit 6 of the first register drives xtal_en: 1 means the crystal is on and 0 means it is powered down.
- R6: Bit 3 (core_en), bit 4 (periph_en) and bit 5 (pll_en) power down when cleared, with these limits. The PLL is cleared only if bits 3, 4 and 5 are all 0 in the same write. The peripheral domain is cleared only if bits 3 and 4 are both 0. In any other combination the affected flag stays 1.
- R7: A cycle with wake high sets bits 3, 4 and 5 of the first register on that edge. This takes priority over a write committed on the same edge.
- R8: In the second register, bit 8 is pwm_en, bit 5 is uart_en and bit 2 is spi_i2c_en (1 means enabled). It resets to 0x0124. All other bits are stored as 0.
- R9: Any other bus write that falls between a key and its target disarms the sequence. The target register then keeps its previous value.
- R10: The key addresses 0x0, 0x2 and 0x4 read as 0. The power registers read back their stored value. The outputs change on the clock edge that commits a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| wake | input | 1 | Wake-up event, restores core, peripheral and PLL flags |
| clk_div_sel | output | 3 | Core clock divide code |
| xtal_en | output | 1 | Crystal circuitry enable |
| pll_en | output | 1 | PLL enable |
| periph_en | output | 1 | Peripheral domain enable |
| core_en | output | 1 | Core enable |
| pwm_en | output | 1 | PWM block enable |
| uart_en | output | 1 | UART enable |
| spi_i2c_en | output | 1 | SPI/I2C block enable |

## Verification
A write, a key commit and a wake pulse each act on the first rising edge after they are presented. Their effect on the outputs and on read data is therefore due one cycle later. Read data is combinational, so it is due in the same cycle the address is driven. The bench drives every input on the falling edge and checks the outputs on the next falling edge, which is half a period after the edge that must have changed them. Reads are sampled shortly after the address settles. For the second register, the bench reads between the data write and the trailing key to confirm that nothing commits early.

// File: rtl/pwr_ctl_keyed.sv
module pwr_ctl_keyed #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter logic [AW-1:0] A_KEY0  = 4'h0,
  parameter logic [AW-1:0] A_PCTL0 = 4'h1,
  parameter logic [AW-1:0] A_KEY1  = 4'h2,
  parameter logic [AW-1:0] A_PCTL1 = 4'h3,
  parameter logic [AW-1:0] A_KEY2  = 4'h4,
  parameter logic [DW-1:0] KEY0_VAL = 16'h0001,
  parameter logic [DW-1:0] KEY1_VAL = 16'h0076,
  parameter logic [DW-1:0] KEY2_VAL = 16'h00B1,
  parameter logic [7:0]    PCTL0_RST = 8'h7B,
  parameter int PWM_BIT  = 8,
  parameter int UART_BIT = 5,
  parameter int SPI_BIT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          wake,
  output logic [2:0]    clk_div_sel,
  output logic          xtal_en,
  output logic          pll_en,
  output logic          periph_en,
  output logic          core_en,
  output logic          pwm_en,
  output logic          uart_en,
  output logic          spi_i2c_en
);

  localparam logic [DW-1:0] PCTL1_MASK =
    (DW'(1) << PWM_BIT) | (DW'(1) << UART_BIT) | (DW'(1) << SPI_BIT);

  logic [7:0]    pctl0;
  logic [DW-1:0] pctl1;
  logic [DW-1:0] pend_val;
  logic          arm0, arm1, pend1;
  logic          wr_key0, wr_key1, wr_key2;
  logic          wr_pctl0, wr_pctl1;
  logic [7:0]    legal0;

  assign wr_key0  = bus_we && (bus_addr == A_KEY0) && (bus_wdata == KEY0_VAL);
  assign wr_key1  = bus_we && (bus_addr == A_KEY1) && (bus_wdata == KEY1_VAL);
  assign wr_key2  = bus_we && (bus_addr == A_KEY2) && (bus_wdata == KEY2_VAL);
  assign wr_pctl0 = bus_we && (bus_addr == A_PCTL0);
  assign wr_pctl1 = bus_we && (bus_addr == A_PCTL1);

  // a domain may drop only together with every domain that depends on it
  always_comb begin
    legal0      = 8'h00;
    legal0[2:0] = bus_wdata[2:0];
    legal0[3]   = bus_wdata[3];
    legal0[4]   = bus_wdata[4] | bus_wdata[3];
    legal0[5]   = bus_wdata[5] | bus_wdata[4] | bus_wdata[3];
    legal0[6]   = bus_wdata[6];
    legal0[7]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pctl0    <= PCTL0_RST;
      pctl1    <= PCTL1_MASK;
      pend_val <= '0;
      arm0     <= 1'b0;
      arm1     <= 1'b0;
      pend1    <= 1'b0;
    end else begin
      if (bus_we) begin
        arm0  <= wr_key0;
        arm1  <= wr_key1;
        pend1 <= wr_pctl1 && arm1;
        if (wr_pctl1) pend_val <= bus_wdata & PCTL1_MASK;
      end
      if (wr_pctl0 && arm0) pctl0 <= legal0;
      if (wr_key2 && pend1) pctl1 <= pend_val;
      if (wake) pctl0[5:3] <= 3'b111;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_PCTL0)      bus_rdata = {{(DW-8){1'b0}}, pctl0};
    else if (bus_addr == A_PCTL1) bus_rdata = pctl1;
  end

  assign clk_div_sel = pctl0[2:0];
  assign core_en     = pctl0[3];
  assign periph_en   = pctl0[4];
  assign pll_en      = pctl0[5];
  assign xtal_en     = pctl0[6];
  assign pwm_en      = pctl1[PWM_BIT];
  assign uart_en     = pctl1[UART_BIT];
  assign spi_i2c_en  = pctl1[SPI_BIT];

endmodule

// File: rtl/pwr_ctl_keyed_chk.sv
module pwr_ctl_keyed_chk #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter logic [AW-1:0] A_KEY0  = 4'h0,
  parameter logic [AW-1:0] A_PCTL0 = 4'h1,
  parameter logic [AW-1:0] A_KEY1  = 4'h2,
  parameter logic [AW-1:0] A_KEY2  = 4'h4,
  parameter logic [DW-1:0] KEY0_VAL = 16'h0001,
  parameter logic [DW-1:0] KEY2_VAL = 16'h00B1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          wake,
  input logic [2:0]    clk_div_sel,
  input logic          xtal_en,
  input logic          pll_en,
  input logic          periph_en,
  input logic          core_en,
  input logic          pwm_en,
  input logic          uart_en,
  input logic          spi_i2c_en
);

  logic last_was_k0;
  always_ff @(posedge clk) begin
    if (!rst_n) last_was_k0 <= 1'b0;
    else if (bus_we) last_was_k0 <= (bus_addr == A_KEY0) && (bus_wdata == KEY0_VAL);
  end

  AST_PCTL0_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PCTL0 && !last_was_k0 && !wake) |=>
      $stable({clk_div_sel, xtal_en, pll_en, periph_en, core_en})); // R1

  AST_PCTL1_NEEDS_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_KEY2 && bus_wdata == KEY2_VAL) |=>
      $stable({pwm_en, uart_en, spi_i2c_en})); // R2

  AST_BIT7_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_PCTL0) |-> (bus_rdata[DW-1:7] == '0)); // R3

  AST_PLL_DOWN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> (!core_en && !periph_en)); // R6

  AST_PERIPH_DOWN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_en) |-> !core_en); // R6

  AST_WAKE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (core_en && periph_en && pll_en)); // R7

  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_KEY0 || bus_addr == A_KEY1 || bus_addr == A_KEY2) |->
      (bus_rdata == '0)); // R10

endmodule

bind pwr_ctl_keyed pwr_ctl_keyed_chk u_chk (.*);

// File: tb/sim_pwr_ctl_keyed.sv
`timescale 1ns/1ps
module sim_pwr_ctl_keyed;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        wake = 1'b0;
  logic [2:0]  clk_div_sel;
  logic        xtal_en, pll_en, periph_en, core_en, pwm_en, uart_en, spi_i2c_en;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pwr_ctl_keyed u0 (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, $sformatf("read addr %0h", a), int'(v), int'(exp));
  endtask

  task automatic put0(input logic [15:0] d);
    wr(4'h0, 16'h0001);
    wr(4'h1, d);
  endtask

  task automatic t_reset;
    rd_chk("R3", 4'h1, 16'h007B);
    rd_chk("R8", 4'h3, 16'h0124);
    chk("R4", "clk_div_sel", clk_div_sel, 3);
    chk("R6", "domain enables", {xtal_en, pll_en, periph_en, core_en}, 4'hF);
    chk("R8", "peripheral enables", {pwm_en, uart_en, spi_i2c_en}, 3'b111);
  endtask

  task automatic t_key0;
    wr(4'h1, 16'h0040);
    rd_chk("R1", 4'h1, 16'h007B);
    chk("R1", "xtal_en unkeyed", xtal_en, 1);
    put0(16'h007D);
    rd_chk("R1", 4'h1, 16'h007D);
    chk("R4", "clk_div_sel code 5", clk_div_sel, 5);
    chk("R10", "outputs updated at commit edge", clk_div_sel, 5);
    wr(4'h0, 16'h0002);
    wr(4'h1, 16'h0078);
    rd_chk("R1", 4'h1, 16'h007D);
    wr(4'h0, 16'h0001);
    repeat (3) @(negedge clk);
    wr(4'h1, 16'h0079);
    rd_chk("R1", 4'h1, 16'h0079);
    chk("R4", "clk_div_sel code 1", clk_div_sel, 1);
    put0(16'h00FB);
    rd_chk("R3", 4'h1, 16'h007B);
    wr(4'h0, 16'h0001);
    wr(4'h2, 16'h0076);
    wr(4'h1, 16'h0000);
    rd_chk("R9", 4'h1, 16'h007B);
    chk("R9", "core_en after disarm", core_en, 1);
  endtask

  task automatic t_legal;
    put0(16'h003B);
    chk("R5", "xtal_en cleared", xtal_en, 0);
    put0(16'h0073);
    rd_chk("R6", 4'h1, 16'h0073);
    chk("R6", "core only off", {pll_en, periph_en, core_en}, 3'b110);
    put0(16'h006B);
    rd_chk("R6", 4'h1, 16'h007B);
    chk("R6", "periph alone refused", periph_en, 1);
    put0(16'h005B);
    rd_chk("R6", 4'h1, 16'h007B);
    chk("R6", "pll alone refused", pll_en, 1);
    put0(16'h0063);
    rd_chk("R6", 4'h1, 16'h0063);
    chk("R6", "periph+core off, pll on", {pll_en, periph_en, core_en}, 3'b100);
    put0(16'h0043);
    rd_chk("R6", 4'h1, 16'h0043);
    chk("R6", "all three off", {pll_en, periph_en, core_en}, 3'b000);
  endtask

  task automatic t_wake;
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    rd_chk("R7", 4'h1, 16'h007B);
    chk("R7", "wake restore", {pll_en, periph_en, core_en}, 3'b111);
    wr(4'h0, 16'h0001);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'h1; bus_wdata = 16'h0043; wake = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; wake = 1'b0;
    rd_chk("R7", 4'h1, 16'h007B);
  endtask

  task automatic t_pctl1;
    wr(4'h2, 16'h0076);
    wr(4'h3, 16'h0020);
    rd_chk("R2", 4'h3, 16'h0124);
    chk("R2", "pwm before trailing key", pwm_en, 1);
    wr(4'h4, 16'h00B1);
    rd_chk("R2", 4'h3, 16'h0020);
    chk("R8", "uart only", {pwm_en, uart_en, spi_i2c_en}, 3'b010);
    wr(4'h2, 16'h0076);
    wr(4'h3, 16'h0100);
    wr(4'h4, 16'h00B0);
    rd_chk("R2", 4'h3, 16'h0020);
    wr(4'h3, 16'h0104);
    wr(4'h4, 16'h00B1);
    rd_chk("R2", 4'h3, 16'h0020);
    wr(4'h2, 16'h0076);
    wr(4'h3, 16'h0004);
    wr(4'h1, 16'h0000);
    wr(4'h4, 16'h00B1);
    rd_chk("R9", 4'h3, 16'h0020);
    wr(4'h2, 16'h0076);
    wr(4'h3, 16'hFFFF);
    wr(4'h4, 16'h00B1);
    rd_chk("R8", 4'h3, 16'h0124);
    chk("R8", "all enabled", {pwm_en, uart_en, spi_i2c_en}, 3'b111);
    rd_chk("R10", 4'h0, 16'h0000);
    rd_chk("R10", 4'h2, 16'h0000);
    rd_chk("R10", 4'h4, 16'h0000);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_key0();
    t_legal();
    t_wake();
    t_pctl1();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule